// File: doc/BRIEF.md
# SIMT Divergence Mask Stack

This block tracks which lanes of a 32-lane SIMT group are allowed to commit results while one shared instruction stream runs through nested if/else regions. Every lane executes every instruction on both sides of a branch; the mask chosen here decides which lanes keep their results. When the sequencer reaches a branch that may split the group, it issues a diverge step together with the per-lane predicate bits. The block then saves the current mask on an internal stack and keeps only the lanes that are both active and predicated true. A flip step at the start of the else side activates the remaining lanes of the saved mask. A rejoin step at the reconvergence point restores the saved mask and releases the stack entry.

Nesting depth is a parameter. Stack misuse never corrupts the state. A diverge on a full stack is refused and flagged as overflow. A flip or rejoin with nothing saved is refused and flagged as underflow. A skip output tells the sequencer that no lane is active, so it can jump past an empty path.

Top module: `simt_mask_stack`

## Requirements
- R1: After reset the active mask is all ones, the depth is 0, and overflow, underflow and skip are low.
- R2: A diverge step (op code 2'b01) with the stack not full saves the current mask, sets the active mask to the old mask ANDed with the predicate, and increases the depth by one, all visible after the next rising clock edge.
- R3: A diverge step with depth equal to DEPTH leaves mask and depth unchanged and raises overflow for exactly the following cycle.
- R4: A flip step (op code 2'b10) with a non-empty stack sets the active mask to the top saved mask ANDed with the inverse of the current mask, and leaves the depth unchanged.
- R5: A rejoin step (op code 2'b11) with a non-empty stack restores the top saved mask and decreases the depth by one.
- R6: A rejoin step with depth 0 keeps the mask and depth and raises underflow for exactly the following cycle.
- R7: A flip step with depth 0 keeps the mask and depth and raises underflow for exactly the following cycle.
- R8: The skip output is high exactly when the active mask has no bit set.
- R9: The idle op code 2'b00 changes neither the mask nor the depth, whatever the predicate input carries.
- R10: Across several nesting levels, rejoin steps restore the saved masks in last-in, first-out order.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Active-low synchronous reset |
| op_i | input | 2 | Step code: 00 idle, 01 diverge, 10 flip, 11 rejoin |
| pred_i | input | LANES | Per-lane predicate bits, used on diverge |
| active_mask_o | output | LANES | Lanes allowed to commit |
| depth_o | output | $clog2(DEPTH+1) | Number of saved masks |
| overflow_o | output | 1 | Diverge refused on a full stack (one-cycle pulse) |
| underflow_o | output | 1 | Flip or rejoin refused on an empty stack (one-cycle pulse) |
| skip_o | output | 1 | No lane is active |

## Verification
On every cycle the assertions check the following. An accepted diverge only narrows the mask and adds one level. An accepted flip yields lanes disjoint from the previous mask. An idle step keeps the mask. Refused steps freeze the depth and pulse the matching flag. Exact mask values after a flip or rejoin depend on what was saved earlier, so they come from the bench's scenarios. These scenarios include a nested if/else walk, a fill to overflow, a deep LIFO unwind and misuse on an empty stack.

// File: rtl/simt_mask_pkg.sv
package simt_mask_pkg;
   typedef enum logic [1:0] {
      OP_NONE    = 2'b00,
      OP_DIVERGE = 2'b01,
      OP_FLIP    = 2'b10,
      OP_REJOIN  = 2'b11
   } mask_op_e;
endpackage

// File: rtl/simt_mask_regfile.sv
module simt_mask_regfile #(
   parameter int W     = 32,
   parameter int DEPTH = 8,
   localparam int IW   = (DEPTH > 1) ? $clog2(DEPTH) : 1
) (
   input  logic          clk,
   input  logic          rst_n,
   input  logic          wr_en,
   input  logic [IW-1:0] wr_idx,
   input  logic [W-1:0]  wr_data,
   input  logic [IW-1:0] rd_idx,
   output logic [W-1:0]  rd_data
);
   logic [W-1:0] slot_q [DEPTH];

   for (genvar e = 0; e < DEPTH; e++) begin : g_slot
      always_ff @(posedge clk) begin
         if (!rst_n)
            slot_q[e] <= '0;
         else if (wr_en && (wr_idx == IW'(e)))
            slot_q[e] <= wr_data;
      end
   end

   always_comb begin
      rd_data = '0;
      for (int e = 0; e < DEPTH; e++)
         if (rd_idx == IW'(e))
            rd_data = rd_data | slot_q[e];
   end
endmodule

// File: rtl/simt_mask_ctrl.sv
module simt_mask_ctrl
   import simt_mask_pkg::*;
#(
   parameter int DEPTH = 8,
   localparam int DW   = $clog2(DEPTH + 1),
   localparam int IW   = (DEPTH > 1) ? $clog2(DEPTH) : 1
) (
   input  logic          clk,
   input  logic          rst_n,
   input  mask_op_e      op,
   output logic          push_ok,
   output logic          flip_ok,
   output logic          pop_ok,
   output logic [IW-1:0] wr_idx,
   output logic [IW-1:0] rd_idx,
   output logic [DW-1:0] depth_o,
   output logic          overflow_o,
   output logic          underflow_o
);
   logic [DW-1:0] depth_q;
   logic [DW-1:0] top_full;
   logic          full, empty, is_push, is_flip, is_pop;
   logic          ovf_q, unf_q;

   assign full     = (depth_q == DW'(DEPTH));
   assign empty    = (depth_q == '0);
   assign is_push  = (op == OP_DIVERGE);
   assign is_flip  = (op == OP_FLIP);
   assign is_pop   = (op == OP_REJOIN);
   assign push_ok  = is_push && !full;
   assign flip_ok  = is_flip && !empty;
   assign pop_ok   = is_pop && !empty;
   assign top_full = depth_q - DW'(1);
   assign rd_idx   = top_full[IW-1:0];
   assign wr_idx   = depth_q[IW-1:0];

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         depth_q <= '0;
         ovf_q   <= 1'b0;
         unf_q   <= 1'b0;
      end else begin
         if (push_ok)
            depth_q <= depth_q + DW'(1);
         else if (pop_ok)
            depth_q <= depth_q - DW'(1);
         ovf_q <= is_push && full;
         unf_q <= (is_flip || is_pop) && empty;
      end
   end

   assign depth_o     = depth_q;
   assign overflow_o  = ovf_q;
   assign underflow_o = unf_q;

   assert_depth_bound_R3: assert property (@(posedge clk) disable iff (!rst_n)
      depth_q <= DW'(DEPTH));
   assert_push_depth_R2: assert property (@(posedge clk) disable iff (!rst_n)
      push_ok |=> depth_q == $past(depth_q) + DW'(1));
   assert_no_overflow_R3: assert property (@(posedge clk) disable iff (!rst_n)
      (is_push && full) |=> overflow_o && $stable(depth_q));
   assert_pop_underflow_R6: assert property (@(posedge clk) disable iff (!rst_n)
      (is_pop && empty) |=> underflow_o && depth_q == '0);
   assert_flip_underflow_R7: assert property (@(posedge clk) disable iff (!rst_n)
      (is_flip && empty) |=> underflow_o && depth_q == '0);
   assert_flip_depth_R4: assert property (@(posedge clk) disable iff (!rst_n)
      flip_ok |=> $stable(depth_q));
endmodule

// File: rtl/simt_mask_lanes.sv
module simt_mask_lanes #(
   parameter int LANES = 32
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             push_ok,
   input  logic             flip_ok,
   input  logic             pop_ok,
   input  logic [LANES-1:0] pred,
   input  logic [LANES-1:0] saved,
   output logic [LANES-1:0] active_o,
   output logic             skip_o
);
   logic [LANES-1:0] act_q, act_d;

   for (genvar l = 0; l < LANES; l++) begin : g_lane
      always_comb begin
         if (push_ok)
            act_d[l] = act_q[l] & pred[l];
         else if (flip_ok)
            act_d[l] = saved[l] & ~act_q[l];
         else if (pop_ok)
            act_d[l] = saved[l];
         else
            act_d[l] = act_q[l];
      end
   end

   always_ff @(posedge clk) begin
      if (!rst_n)
         act_q <= '1;
      else
         act_q <= act_d;
   end

   assign active_o = act_q;
   assign skip_o   = ~|act_q;

   assert_push_narrows_R2: assert property (@(posedge clk) disable iff (!rst_n)
      push_ok |=> (act_q & ~$past(act_q)) == '0);
   assert_flip_disjoint_R4: assert property (@(posedge clk) disable iff (!rst_n)
      flip_ok |=> (act_q & $past(act_q)) == '0);
   assert_idle_hold_R9: assert property (@(posedge clk) disable iff (!rst_n)
      (!push_ok && !flip_ok && !pop_ok) |=> $stable(act_q));
endmodule

// File: rtl/simt_mask_stack.sv
module simt_mask_stack
   import simt_mask_pkg::*;
#(
   parameter int LANES = 32,
   parameter int DEPTH = 8,
   localparam int DW   = $clog2(DEPTH + 1),
   localparam int IW   = (DEPTH > 1) ? $clog2(DEPTH) : 1
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic [1:0]       op_i,
   input  logic [LANES-1:0] pred_i,
   output logic [LANES-1:0] active_mask_o,
   output logic [DW-1:0]    depth_o,
   output logic             overflow_o,
   output logic             underflow_o,
   output logic             skip_o
);
   if (LANES < 1) begin : g_bad_lanes
      $error("simt_mask_stack: LANES must be at least 1");
   end
   if (DEPTH < 1) begin : g_bad_depth
      $error("simt_mask_stack: DEPTH must be at least 1");
   end

   logic          push_ok, flip_ok, pop_ok;
   logic [IW-1:0] wr_idx, rd_idx;
   logic [LANES-1:0] saved, active;

   simt_mask_ctrl #(.DEPTH(DEPTH)) ctrl_i (
      .clk         (clk),
      .rst_n       (rst_n),
      .op          (mask_op_e'(op_i)),
      .push_ok     (push_ok),
      .flip_ok     (flip_ok),
      .pop_ok      (pop_ok),
      .wr_idx      (wr_idx),
      .rd_idx      (rd_idx),
      .depth_o     (depth_o),
      .overflow_o  (overflow_o),
      .underflow_o (underflow_o)
   );

   simt_mask_regfile #(.W(LANES), .DEPTH(DEPTH)) store_i (
      .clk     (clk),
      .rst_n   (rst_n),
      .wr_en   (push_ok),
      .wr_idx  (wr_idx),
      .wr_data (active),
      .rd_idx  (rd_idx),
      .rd_data (saved)
   );

   simt_mask_lanes #(.LANES(LANES)) lanes_i (
      .clk      (clk),
      .rst_n    (rst_n),
      .push_ok  (push_ok),
      .flip_ok  (flip_ok),
      .pop_ok   (pop_ok),
      .pred     (pred_i),
      .saved    (saved),
      .active_o (active),
      .skip_o   (skip_o)
   );

   assign active_mask_o = active;

   assert_pop_depth_R5: assert property (@(posedge clk) disable iff (!rst_n)
      pop_ok |=> depth_o == $past(depth_o) - DW'(1));
endmodule

// File: tb/simt_mask_stack_tb_top.sv
module simt_mask_stack_tb_top;
   localparam int LANES = 32;
   localparam int DEPTH = 8;
   localparam int DW    = $clog2(DEPTH + 1);
   localparam int ROWS  = 15;

   logic             clk = 1'b0;
   logic             rst_n = 1'b0;
   logic [1:0]       op = 2'b00;
   logic [LANES-1:0] pred = '0;
   logic [LANES-1:0] mask;
   logic [DW-1:0]    depth;
   logic             ovf, unf, skip;
   int total = 0;
   int bad = 0;
   bit done = 1'b0;

   always #10 clk = ~clk;

   simt_mask_stack #(.LANES(LANES), .DEPTH(DEPTH)) dut_i (
      .clk(clk), .rst_n(rst_n), .op_i(op), .pred_i(pred),
      .active_mask_o(mask), .depth_o(depth), .overflow_o(ovf),
      .underflow_o(unf), .skip_o(skip)
   );

   // {op, pred, expected mask, expected depth, expected ovf, expected unf}
   localparam logic [71:0] TBL [ROWS] = '{
      {2'b01, 32'h0000FFFF, 32'h0000FFFF, 4'd1, 1'b0, 1'b0},
      {2'b01, 32'h00FF00FF, 32'h000000FF, 4'd2, 1'b0, 1'b0},
      {2'b10, 32'h00000000, 32'h0000FF00, 4'd2, 1'b0, 1'b0},
      {2'b01, 32'h0F0F0F0F, 32'h00000F00, 4'd3, 1'b0, 1'b0},
      {2'b10, 32'hFFFFFFFF, 32'h0000F000, 4'd3, 1'b0, 1'b0},
      {2'b11, 32'h00000000, 32'h0000FF00, 4'd2, 1'b0, 1'b0},
      {2'b11, 32'h00000000, 32'h0000FFFF, 4'd1, 1'b0, 1'b0},
      {2'b10, 32'h00000000, 32'hFFFF0000, 4'd1, 1'b0, 1'b0},
      {2'b01, 32'h00000000, 32'h00000000, 4'd2, 1'b0, 1'b0},
      {2'b10, 32'h00000000, 32'hFFFF0000, 4'd2, 1'b0, 1'b0},
      {2'b11, 32'h00000000, 32'hFFFF0000, 4'd1, 1'b0, 1'b0},
      {2'b11, 32'h00000000, 32'hFFFFFFFF, 4'd0, 1'b0, 1'b0},
      {2'b11, 32'h00000000, 32'hFFFFFFFF, 4'd0, 1'b0, 1'b1},
      {2'b10, 32'h00000000, 32'hFFFFFFFF, 4'd0, 1'b0, 1'b1},
      {2'b00, 32'h12345678, 32'hFFFFFFFF, 4'd0, 1'b0, 1'b0}
   };

   task automatic check(input string tag, input logic [31:0] got, input logic [31:0] want);
      total++;
      if (got !== want) begin
         bad++;
         $display("FAIL %s got=%h exp=%h", tag, got, want);
      end
   endtask

   // drive at a falling edge; results are sampled at the next falling edge
   task automatic step(input logic [1:0] o, input logic [LANES-1:0] p);
      op = o;
      pred = p;
      @(negedge clk);
      op = 2'b00;
   endtask

   task automatic do_reset();
      rst_n = 1'b0;
      op = 2'b00;
      @(negedge clk);
      @(negedge clk);
      rst_n = 1'b1;
      @(negedge clk);
   endtask

   initial begin
      do_reset();
      check("R1 mask after reset", mask, 32'hFFFFFFFF);
      check("R1 depth after reset", 32'(depth), 0);
      check("R1 flags after reset", {29'd0, ovf, unf, skip}, 0);

      // table walk: R2 diverge, R4 flip, R5 rejoin, R6/R7 empty misuse, R8 skip, R9 idle
      for (int r = 0; r < ROWS; r++) begin
         logic [71:0] v;
         v = TBL[r];
         step(v[71:70], v[69:38]);
         check($sformatf("R2/R4/R5 row %0d mask", r), mask, v[37:6]);
         check($sformatf("R2/R4/R5 row %0d depth", r), 32'(depth), 32'(v[5:2]));
         check($sformatf("R3 row %0d overflow", r), 32'(ovf), 32'(v[1]));
         check($sformatf("R6/R7 row %0d underflow", r), 32'(unf), 32'(v[0]));
         check($sformatf("R8 row %0d skip", r), 32'(skip), 32'(v[37:6] == 0));
      end

      // R3: fill the stack, then one more diverge is refused
      for (int k = 0; k < DEPTH; k++) step(2'b01, 32'hFFFFFFFF);
      check("R3 full depth", 32'(depth), DEPTH);
      step(2'b01, 32'h0);
      check("R3 overflow raised", 32'(ovf), 1);
      check("R3 mask unchanged", mask, 32'hFFFFFFFF);
      check("R3 depth unchanged", 32'(depth), DEPTH);
      step(2'b00, 32'h0);
      check("R3 overflow one cycle", 32'(ovf), 0);

      // R1: reset mid-run clears stack
      do_reset();
      check("R1 mid-run depth", 32'(depth), 0);
      check("R1 mid-run mask", mask, 32'hFFFFFFFF);

      // R10: deep nesting, unwind in LIFO order
      for (int k = 0; k < DEPTH; k++) begin
         step(2'b01, ~(32'h1 << k));
         check($sformatf("R10 nest %0d mask", k), mask, 32'hFFFFFFFF << (k + 1));
      end
      for (int k = DEPTH - 1; k >= 0; k--) begin
         step(2'b11, 32'h0);
         check($sformatf("R10 unwind %0d mask", k), mask, 32'hFFFFFFFF << k);
         check($sformatf("R10 unwind %0d depth", k), 32'(depth), k);
      end

      // R9: idle with busy predicate input leaves everything alone
      step(2'b01, 32'hA5A5A5A5);
      for (int k = 0; k < 3; k++) begin
         step(2'b00, 32'h5A5A5A5A ^ k);
         check("R9 idle mask", mask, 32'hA5A5A5A5);
         check("R9 idle depth", 32'(depth), 1);
      end

      // R8: flip onto empty complement then skip drops after rejoin
      step(2'b01, 32'hFFFFFFFF);
      step(2'b10, 32'h0);
      check("R8 empty else skip", 32'(skip), 1);
      check("R4 empty else mask", mask, 32'h0);
      step(2'b11, 32'h0);
      check("R8 skip low after rejoin", 32'(skip), 0);
      check("R5 rejoin mask", mask, 32'hA5A5A5A5);

      done = 1'b1;
      $display("  test done: total=%0d bad=%0d", total, bad);
      $finish;
   end

   initial begin
      repeat (50000) @(posedge clk);
      if (!done) begin
         total++;
         bad++;
         $display("FAIL watchdog got=hung exp=finished");
         $display("  test done: total=%0d bad=%0d", total, bad);
         $finish;
      end
   end
endmodule